// File: doc/BRIEF.md
# Low-Power Operating Mode Controller

This block keeps track of the power mode a small microcontroller is in. The modes are a reset state, three running modes (full-speed active, divided-clock active and a low-speed subactive mode) and three stopped modes (sleep, standby and watch). Two things change the mode: a one-cycle strobe that the core raises when it executes its sleep instruction, and qualified interrupt requests. The mode register changes only on the rising clock edge. The reset pin forces the reset state at once and with no clock. Its release is resynchronised before the block leaves that state.

The mode reached on the sleep strobe depends on three control bits: standby select, low-speed select and watch-timer select. The mode reached on a wakeup depends on the low-speed and medium-speed selects. A request wakes the block only if three things hold: the global interrupt mask is clear, the request's own enable is set, and its source belongs to the set that the current stopped mode listens to. The block also drives a one-hot mode vector and a 2-bit clock-divider select for the clock generator.

Top module: `pmc_mode_ctrl`

## Requirements
- R1: While `pin_rst_n` is low, `mode_oh` is 7'b0000001 (reset). This takes effect without waiting for a clock edge, whatever the previous mode.
- R2: After `pin_rst_n` rises, `mode_oh` stays at reset through the first two rising edges. It becomes 7'b0000100 (divided-clock active) on the third rising edge.
- R3: A sleep strobe in an active mode (bit 1, 2 or 6 of `mode_oh`) with `sel_stby`=1 and `sel_wtimer`=1 enters watch mode (7'b0100000) on the next edge. `sel_lowspd` has no effect on this.
- R4: A sleep strobe in an active mode with `sel_stby`=1, `sel_lowspd`=0 and `sel_wtimer`=0 enters standby (7'b0010000).
- R5: A sleep strobe in an active mode with `sel_stby`=0 and `sel_lowspd`=0 enters sleep (7'b0001000).
- R6: A sleep strobe in an active mode with `sel_lowspd`=1 and no watch selection (`sel_stby`=0, or `sel_wtimer`=0) leaves the mode unchanged.
- R7: A sleep strobe has no effect in reset, sleep, standby or watch.
- R8: In standby, only IRQ0, IRQ1 and the wakeup pins can wake the block. Timer A, timer F and the generic request are ignored.
- R9: In watch, only timer A, timer F, IRQ0 and the wakeup pins can wake the block. IRQ1 and the generic request are ignored.
- R10: In sleep, every source (IRQ0, IRQ1, wakeup pins, timer A, timer F, generic) can wake the block.
- R11: No wakeup happens while `int_mask`=1, or when the requesting source's enable is 0.
- R12: A wakeup takes effect on the next edge. It goes to subactive (7'b1000000) when `sel_lowspd`=1. Otherwise it goes to divided-clock active (7'b0000100) when `sel_medspd`=1, and to full-speed active (7'b0000010) when both are 0.
- R13: In divided-clock active mode, `div_sel` equals `clk_ratio` (00=/16, 01=/32, 10=/64, 11=/128). In every other mode it is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pin_rst_n | input | 1 | Active-low reset pin, asserts asynchronously |
| sleep_stb | input | 1 | One-cycle sleep-instruction strobe |
| sel_stby | input | 1 | Standby select |
| sel_lowspd | input | 1 | Low-speed select |
| sel_medspd | input | 1 | Medium-speed select for wakeup target |
| sel_wtimer | input | 1 | Watch-timer select |
| clk_ratio | input | 2 | Divided-clock ratio code |
| int_mask | input | 1 | Global interrupt mask, 1 blocks wakeup |
| irq0_req | input | 1 | IRQ0 request |
| irq0_en | input | 1 | IRQ0 enable |
| irq1_req | input | 1 | IRQ1 request |
| irq1_en | input | 1 | IRQ1 enable |
| wkp_req | input | 8 | Wakeup pin requests |
| wkp_en | input | 8 | Wakeup pin enables |
| tma_req | input | 1 | Timer A request |
| tma_en | input | 1 | Timer A enable |
| tmf_req | input | 1 | Timer F request |
| tmf_en | input | 1 | Timer F enable |
| gen_req | input | 1 | Generic interrupt request |
| gen_en | input | 1 | Generic interrupt enable |
| mode_oh | output | 7 | One-hot mode: 0 reset, 1 full-speed, 2 divided, 3 sleep, 4 standby, 5 watch, 6 subactive |
| div_sel | output | 2 | Clock-divider select |

## Verification
The bench targets the sources that differ between the wake sets of watch and standby. A design that shared one wake set between the two would wake from standby on a timer event, or stay stuck in watch when timer A fires. It also sends sleep strobes with the low-speed bit set, and while the block is already stopped. A decoder that is too loose would fall into standby or sleep there, or chain from sleep into watch. Further checks apply the mask and a cleared enable, and count the exact edges from reset release to the first active mode. An off-by-one in the synchroniser, or a wake path that ignores the gating, shows up at once.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    // Mode encoding doubles as the one-hot bit position.
    typedef enum logic [2:0] {
        PM_RESET   = 3'd0,
        PM_ACT_HI  = 3'd1,
        PM_ACT_MED = 3'd2,
        PM_SLEEP   = 3'd3,
        PM_STBY    = 3'd4,
        PM_WATCH   = 3'd5,
        PM_SUBACT  = 3'd6
    } pm_mode_t;

    localparam int PM_COUNT = 7;

    // Flat wake-source vector layout; wakeup pins follow the fixed sources.
    localparam int SRC_IRQ0  = 0;
    localparam int SRC_IRQ1  = 1;
    localparam int SRC_TMA   = 2;
    localparam int SRC_TMF   = 3;
    localparam int SRC_GEN   = 4;
    localparam int SRC_FIXED = 5;

    typedef struct packed {
        logic stby;
        logic lowspd;
        logic medspd;
        logic wtimer;
    } pm_ctrl_t;

    function automatic logic pm_is_active(pm_mode_t m);
        return (m == PM_ACT_HI) || (m == PM_ACT_MED) || (m == PM_SUBACT);
    endfunction

    function automatic logic pm_is_stopped(pm_mode_t m);
        return (m == PM_SLEEP) || (m == PM_STBY) || (m == PM_WATCH);
    endfunction

    function automatic logic [PM_COUNT-1:0] pm_onehot(pm_mode_t m);
        logic [PM_COUNT-1:0] v;
        v = '0;
        v[m] = 1'b1;
        return v;
    endfunction

    // Mode reached after a qualified wakeup.
    function automatic pm_mode_t pm_wake_target(pm_ctrl_t c);
        if (c.lowspd)      return PM_SUBACT;
        else if (c.medspd) return PM_ACT_MED;
        else               return PM_ACT_HI;
    endfunction

endpackage

// File: rtl/pmc_rel_sync.sv
module pmc_rel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_rst_n,
    output logic rel_o
);
    logic [STAGES-1:0] q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge pin_rst_n) begin
                if (!pin_rst_n) q <= 1'b0;
                else            q <= 1'b1;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge pin_rst_n) begin
                if (!pin_rst_n) q <= '0;
                else            q <= {q[STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    assign rel_o = q[STAGES-1];

    // R2: release only ever rises after the pin has been high for a cycle
    p_rel_after_pin_r2: assert property (@(posedge clk) disable iff (!pin_rst_n)
        $rose(rel_o) |-> $past(pin_rst_n));

endmodule

// File: rtl/pmc_wake_qual.sv
module pmc_wake_qual
    import pmc_pkg::*;
#(
    parameter int NUM_WKP = 8,
    localparam int NSRC = SRC_FIXED + NUM_WKP
) (
    input  pm_mode_t        mode_i,
    input  logic            int_mask,
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] en_i,
    output logic            hit_o
);
    logic [NSRC-1:0] allow;

    // Per-source membership in each stopped mode's wake set.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        localparam bit IS_PIN   = (g >= SRC_FIXED);
        localparam bit STBY_OK  = (g == SRC_IRQ0) || (g == SRC_IRQ1) || IS_PIN;
        localparam bit WATCH_OK = (g == SRC_IRQ0) || (g == SRC_TMA) ||
                                  (g == SRC_TMF)  || IS_PIN;
        assign allow[g] = (mode_i == PM_SLEEP) ||
                          ((mode_i == PM_STBY)  && STBY_OK) ||
                          ((mode_i == PM_WATCH) && WATCH_OK);
    end

    assign hit_o = !int_mask && (|(req_i & en_i & allow));

endmodule

// File: rtl/pmc_sleep_dec.sv
module pmc_sleep_dec
    import pmc_pkg::*;
(
    input  pm_mode_t mode_i,
    input  logic     sleep_stb,
    input  logic     sel_stby,
    input  logic     sel_lowspd,
    input  logic     sel_wtimer,
    output logic     go_o,
    output pm_mode_t target_o
);
    logic armed;
    assign armed = sleep_stb && pm_is_active(mode_i);

    always_comb begin
        go_o     = 1'b0;
        target_o = mode_i;
        if (armed) begin
            if (sel_stby && sel_wtimer) begin
                go_o     = 1'b1;
                target_o = PM_WATCH;
            end else if (sel_stby && !sel_lowspd) begin
                go_o     = 1'b1;
                target_o = PM_STBY;
            end else if (!sel_stby && !sel_lowspd) begin
                go_o     = 1'b1;
                target_o = PM_SLEEP;
            end
        end
    end

endmodule

// File: rtl/pmc_mode_ctrl.sv
module pmc_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int NUM_WKP    = 8,
    parameter int REL_STAGES = 2,
    localparam int NSRC = SRC_FIXED + NUM_WKP
) (
    input  logic               clk,
    input  logic               pin_rst_n,
    input  logic               sleep_stb,
    input  logic               sel_stby,
    input  logic               sel_lowspd,
    input  logic               sel_medspd,
    input  logic               sel_wtimer,
    input  logic [1:0]         clk_ratio,
    input  logic               int_mask,
    input  logic               irq0_req,
    input  logic               irq0_en,
    input  logic               irq1_req,
    input  logic               irq1_en,
    input  logic [NUM_WKP-1:0] wkp_req,
    input  logic [NUM_WKP-1:0] wkp_en,
    input  logic               tma_req,
    input  logic               tma_en,
    input  logic               tmf_req,
    input  logic               tmf_en,
    input  logic               gen_req,
    input  logic               gen_en,
    output logic [PM_COUNT-1:0] mode_oh,
    output logic [1:0]         div_sel
);
    pm_mode_t mode_q, mode_d, sleep_tgt;
    pm_ctrl_t ctrl;
    logic     rel, wake_hit, sleep_go;
    logic [NSRC-1:0] req_vec, en_vec;

    assign ctrl    = '{stby: sel_stby, lowspd: sel_lowspd,
                       medspd: sel_medspd, wtimer: sel_wtimer};
    assign req_vec = {wkp_req, gen_req, tmf_req, tma_req, irq1_req, irq0_req};
    assign en_vec  = {wkp_en,  gen_en,  tmf_en,  tma_en,  irq1_en,  irq0_en};

    pmc_rel_sync #(.STAGES(REL_STAGES)) u_rel (
        .clk       (clk),
        .pin_rst_n (pin_rst_n),
        .rel_o     (rel)
    );

    pmc_wake_qual #(.NUM_WKP(NUM_WKP)) u_wake (
        .mode_i   (mode_q),
        .int_mask (int_mask),
        .req_i    (req_vec),
        .en_i     (en_vec),
        .hit_o    (wake_hit)
    );

    pmc_sleep_dec u_sleep (
        .mode_i     (mode_q),
        .sleep_stb  (sleep_stb),
        .sel_stby   (sel_stby),
        .sel_lowspd (sel_lowspd),
        .sel_wtimer (sel_wtimer),
        .go_o       (sleep_go),
        .target_o   (sleep_tgt)
    );

    always_comb begin
        mode_d = mode_q;
        if (mode_q == PM_RESET) begin
            if (rel) mode_d = PM_ACT_MED;
        end else if (pm_is_active(mode_q)) begin
            if (sleep_go) mode_d = sleep_tgt;
        end else if (pm_is_stopped(mode_q)) begin
            if (wake_hit) mode_d = pm_wake_target(ctrl);
        end else begin
            mode_d = PM_RESET;
        end
    end

    always_ff @(posedge clk or negedge pin_rst_n) begin
        if (!pin_rst_n) mode_q <= PM_RESET;
        else            mode_q <= mode_d;
    end

    assign mode_oh = pm_onehot(mode_q);
    assign div_sel = (mode_q == PM_ACT_MED) ? clk_ratio : 2'b00;

    p_reset_hold_r1: assert property (@(posedge clk)
        !pin_rst_n |-> (mode_oh == 7'b0000001));

    p_release_med_r2: assert property (@(posedge clk) disable iff (!pin_rst_n)
        (mode_q == PM_RESET && rel) |=> (mode_q == PM_ACT_MED));

    p_watch_entry_r3: assert property (@(posedge clk) disable iff (!pin_rst_n)
        (pm_is_active(mode_q) && sleep_stb && sel_stby && sel_wtimer)
        |=> (mode_q == PM_WATCH));

    p_sleep_entry_r5: assert property (@(posedge clk) disable iff (!pin_rst_n)
        (pm_is_active(mode_q) && sleep_stb && !sel_stby && !sel_lowspd)
        |=> (mode_q == PM_SLEEP));

    p_lowspd_hold_r6: assert property (@(posedge clk) disable iff (!pin_rst_n)
        (pm_is_active(mode_q) && sel_lowspd && !(sel_stby && sel_wtimer))
        |=> $stable(mode_q));

    p_stopped_hold_r7: assert property (@(posedge clk) disable iff (!pin_rst_n)
        (pm_is_stopped(mode_q) && !wake_hit) |=> $stable(mode_q));

    p_mask_blocks_r11: assert property (@(posedge clk) disable iff (!pin_rst_n)
        (pm_is_stopped(mode_q) && int_mask) |=> $stable(mode_q));

    p_div_med_r13: assert property (@(posedge clk) disable iff (!pin_rst_n)
        (mode_oh[2]) |-> (div_sel == clk_ratio));

endmodule

// File: tb/test_pmc_mode_ctrl.sv
`timescale 1ns/1ps
module test_pmc_mode_ctrl;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic pin_rst_n, sleep_stb, sel_stby, sel_lowspd, sel_medspd, sel_wtimer;
    logic [1:0] clk_ratio;
    logic int_mask, irq0_req, irq0_en, irq1_req, irq1_en;
    logic [7:0] wkp_req, wkp_en;
    logic tma_req, tma_en, tmf_req, tmf_en, gen_req, gen_en;
    logic [6:0] mode_oh;
    logic [1:0] div_sel;

    int n_chk = 0, n_fail = 0;

    localparam logic [6:0] M_RST = 7'b0000001, M_HI = 7'b0000010,
                           M_MED = 7'b0000100, M_SLP = 7'b0001000,
                           M_SBY = 7'b0010000, M_WCH = 7'b0100000,
                           M_SUB = 7'b1000000;

    pmc_mode_ctrl i_pmc_mode_ctrl (
        .clk(clk), .pin_rst_n(pin_rst_n), .sleep_stb(sleep_stb),
        .sel_stby(sel_stby), .sel_lowspd(sel_lowspd), .sel_medspd(sel_medspd),
        .sel_wtimer(sel_wtimer), .clk_ratio(clk_ratio), .int_mask(int_mask),
        .irq0_req(irq0_req), .irq0_en(irq0_en), .irq1_req(irq1_req),
        .irq1_en(irq1_en), .wkp_req(wkp_req), .wkp_en(wkp_en),
        .tma_req(tma_req), .tma_en(tma_en), .tmf_req(tmf_req), .tmf_en(tmf_en),
        .gen_req(gen_req), .gen_en(gen_en), .mode_oh(mode_oh), .div_sel(div_sel)
    );

    // {stby,lowspd,medspd,wtimer, sleep, mask, en_ok, src[3:0], expect[6:0], req[3:0]}
    // src: 0 none,1 irq0,2 irq1,3 pin3,4 timerA,5 timerF,6 generic,7 pin0,8 pin7
    localparam int NV = 29;
    localparam logic [21:0] VECS [0:NV-1] = '{
        {4'b0010, 1'b1, 1'b0, 1'b1, 4'd0, M_SLP, 4'd5 },  // R5
        {4'b1011, 1'b1, 1'b0, 1'b1, 4'd0, M_SLP, 4'd7 },  // R7
        {4'b1011, 1'b0, 1'b0, 1'b1, 4'd6, M_MED, 4'd10},  // R10
        {4'b1011, 1'b1, 1'b0, 1'b1, 4'd0, M_WCH, 4'd3 },  // R3
        {4'b1011, 1'b0, 1'b0, 1'b1, 4'd2, M_WCH, 4'd9 },  // R9
        {4'b1011, 1'b0, 1'b0, 1'b1, 4'd6, M_WCH, 4'd9 },  // R9
        {4'b1011, 1'b0, 1'b1, 1'b1, 4'd4, M_WCH, 4'd11},  // R11
        {4'b1011, 1'b0, 1'b0, 1'b0, 4'd4, M_WCH, 4'd11},  // R11
        {4'b1011, 1'b0, 1'b0, 1'b1, 4'd4, M_MED, 4'd9 },  // R9
        {4'b1010, 1'b1, 1'b0, 1'b1, 4'd0, M_SBY, 4'd4 },  // R4
        {4'b1010, 1'b0, 1'b0, 1'b1, 4'd4, M_SBY, 4'd8 },  // R8
        {4'b1010, 1'b0, 1'b0, 1'b1, 4'd5, M_SBY, 4'd8 },  // R8
        {4'b1010, 1'b0, 1'b0, 1'b1, 4'd6, M_SBY, 4'd8 },  // R8
        {4'b0010, 1'b1, 1'b0, 1'b1, 4'd0, M_SBY, 4'd7 },  // R7
        {4'b1000, 1'b0, 1'b0, 1'b1, 4'd8, M_HI,  4'd12},  // R12
        {4'b0100, 1'b1, 1'b0, 1'b1, 4'd0, M_HI,  4'd6 },  // R6
        {4'b1100, 1'b1, 1'b0, 1'b1, 4'd0, M_HI,  4'd6 },  // R6
        {4'b1101, 1'b1, 1'b0, 1'b1, 4'd0, M_WCH, 4'd3 },  // R3
        {4'b1101, 1'b0, 1'b0, 1'b1, 4'd7, M_SUB, 4'd12},  // R12
        {4'b0010, 1'b1, 1'b0, 1'b1, 4'd0, M_SLP, 4'd5 },  // R5
        {4'b0010, 1'b0, 1'b0, 1'b1, 4'd2, M_MED, 4'd10},  // R10
        {4'b1010, 1'b1, 1'b0, 1'b1, 4'd0, M_SBY, 4'd4 },  // R4
        {4'b1010, 1'b0, 1'b0, 1'b1, 4'd1, M_MED, 4'd8 },  // R8
        {4'b0010, 1'b1, 1'b0, 1'b1, 4'd0, M_SLP, 4'd5 },  // R5
        {4'b0010, 1'b0, 1'b0, 1'b0, 4'd1, M_SLP, 4'd11},  // R11
        {4'b0010, 1'b0, 1'b0, 1'b1, 4'd5, M_MED, 4'd10},  // R10
        {4'b1010, 1'b1, 1'b0, 1'b1, 4'd0, M_SBY, 4'd4 },  // R4
        {4'b1010, 1'b0, 1'b1, 1'b1, 4'd3, M_SBY, 4'd11},  // R11
        {4'b1010, 1'b0, 1'b0, 1'b1, 4'd3, M_MED, 4'd8 }   // R8
    };

    task automatic check(input logic [6:0] act, input logic [6:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sleep_stb = 0; int_mask = 0;
        irq0_req = 0; irq1_req = 0; wkp_req = '0; tma_req = 0; tmf_req = 0; gen_req = 0;
        irq0_en = 1; irq1_en = 1; wkp_en = '1; tma_en = 1; tmf_en = 1; gen_en = 1;
    endtask

    task automatic apply_vec(input logic [21:0] v);
        logic en_ok;
        en_ok = v[15];
        @(negedge clk);
        {sel_stby, sel_lowspd, sel_medspd, sel_wtimer} = v[21:18];
        sleep_stb = v[17];
        int_mask  = v[16];
        case (v[14:11])
            4'd1: begin irq0_req = 1; irq0_en = en_ok; end
            4'd2: begin irq1_req = 1; irq1_en = en_ok; end
            4'd3: begin wkp_req[3] = 1; wkp_en[3] = en_ok; end
            4'd4: begin tma_req = 1; tma_en = en_ok; end
            4'd5: begin tmf_req = 1; tmf_en = en_ok; end
            4'd6: begin gen_req = 1; gen_en = en_ok; end
            4'd7: begin wkp_req[0] = 1; wkp_en[0] = en_ok; end
            4'd8: begin wkp_req[7] = 1; wkp_en[7] = en_ok; end
            default: ;
        endcase
        @(negedge clk);
        idle_inputs();
        check(mode_oh, v[10:4], $sformatf("R%0d vector", v[3:0]));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        pin_rst_n = 0; sel_stby = 0; sel_lowspd = 0; sel_medspd = 1; sel_wtimer = 0;
        clk_ratio = 2'b00;
        idle_inputs();
        repeat (3) @(negedge clk);
        check(mode_oh, M_RST, "R1 reset state");
        check({5'b0, div_sel}, 7'd0, "R13 div in reset");

        // R2 release timing, with an ignored sleep strobe in reset (R7)
        pin_rst_n = 1; sleep_stb = 1;
        @(negedge clk); sleep_stb = 0;
        check(mode_oh, M_RST, "R2 after edge 1");
        @(negedge clk); check(mode_oh, M_RST, "R2 after edge 2 / R7");
        @(negedge clk); check(mode_oh, M_MED, "R2 after edge 3");

        for (int i = 0; i < NV; i++) apply_vec(VECS[i]);

        // R13 divider follows ratio in divided-clock mode
        for (int r = 0; r < 4; r++) begin
            clk_ratio = r[1:0];
            #1 check({5'b0, div_sel}, {5'b0, r[1:0]}, "R13 ratio");
        end
        @(negedge clk);
        {sel_stby, sel_lowspd, sel_medspd, sel_wtimer} = 4'b0010; sleep_stb = 1;
        @(negedge clk); sleep_stb = 0; clk_ratio = 2'b11;
        check(mode_oh, M_SLP, "R5 enter sleep");
        #1 check({5'b0, div_sel}, 7'd0, "R13 div outside divided mode");

        // R1 asynchronous reset away from any edge
        @(negedge clk); #1 pin_rst_n = 0;
        #0.5 check(mode_oh, M_RST, "R1 async assert");
        @(negedge clk); check(mode_oh, M_RST, "R1 held");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule